// File: doc/BRIEF.md
# Gated Parallel-Load Serial Shifter

This block is a chain of stages, eight by default, that captures a word in parallel and then streams it out one bit per clock from the far end of the chain. A rising edge of the single clock either loads the whole word, moves every stage one position toward the output while a serial input fills the first stage, or leaves everything as it was.

Two active-low controls pick the action. The stall control (`stall_n` high means stalled) blocks every update. The load-select control (`load_n`) chooses a parallel capture when low and a shift when high. An active-low clear empties the chain at once, with no clock edge needed, and it overrides everything else.

Only the last stage drives the functional output. The full stage vector is also available on a debug port for observation.

Top module: `pl_shifter`

## Requirements
- R1: While `clr_n` is low, every stage is 0 and `sout` is low. This holds as soon as `clr_n` falls, before any clock edge.
- R2: With `clr_n` high and `stall_n` high, a rising edge leaves every stage unchanged, whatever `load_n`, `pin` and `sin` are.
- R3: With `clr_n` high, `stall_n` low and `load_n` low, a rising edge copies `pin[i]` into stage i for every i. Bit 0 goes to stage 0 and bit WIDTH-1 goes to the last stage.
- R4: With `clr_n` high, `stall_n` low and `load_n` high, a rising edge puts `sin` into stage 0, and each stage i takes the old value of stage i-1.
- R5: `sout` shows the last stage. Right after a load it carries `pin[WIDTH-1]`. After WIDTH shifts, the `sin` values come out in the order they were applied.
- R6: Without a rising clock edge, the stages keep their values even when the control and data inputs change.
- R7: Priority runs in this order: clear first, then stall, then load or shift. A clear applied in mid-cycle drives `sout` low before the next edge, and loads requested during the clear are lost.
- R8: The chain length is the parameter WIDTH (default 8). `stages` shows stage i on bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous active-low clear |
| stall_n | input | 1 | Active-low enable; high freezes the chain |
| load_n | input | 1 | Low: parallel load; high: shift |
| sin | input | 1 | Serial input into stage 0 |
| pin | input | WIDTH | Parallel load word, bit i into stage i |
| sout | output | 1 | Last stage, serial output |
| stages | output | WIDTH | Debug view of all stages |

## Verification
A wrong stage value stays hidden at `sout` until the shifting carries it to the last stage. That can take up to WIDTH-1 edges, so the bench checks the `stages` debug port after every edge and catches the fault one edge after it is made. A wrong bit order shows up on the first `sout` sample after a load, because that sample must equal the top bit of the loaded word. A failure to clear or to hold shows at the ports within one sample, because the bench checks between edges as well as after them.

// File: rtl/pl_shifter_pkg.sv
`timescale 1ns/1ps
package pl_shifter_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SHIFT = 2'd2
  } act_e;
endpackage

// File: rtl/pl_shifter_ctrl.sv
`timescale 1ns/1ps
module pl_shifter_ctrl
  import pl_shifter_pkg::*;
(
  input  logic stall_n,
  input  logic load_n,
  output act_e act
);
  // stall has priority over both load and shift
  always_comb begin
    if (stall_n)     act = ACT_KEEP;
    else if (!load_n) act = ACT_LOAD;
    else              act = ACT_SHIFT;
  end
endmodule

// File: rtl/pl_shifter_chain.sv
`timescale 1ns/1ps
module pl_shifter_chain
  import pl_shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  act_e             act,
  input  logic             sin,
  input  logic [WIDTH-1:0] pin,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] q_nxt;
  logic             upd_en;

  assign upd_en = (act != ACT_KEEP);

  // per-stage next-value selection
  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    logic feed;
    if (g == 0) begin : g_head
      assign feed = sin;
    end else begin : g_body
      assign feed = q[g-1];
    end
    assign q_nxt[g] = (act == ACT_LOAD) ? pin[g] : feed;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)      q <= '0;
    else if (upd_en) q <= q_nxt;
  end

  AST_CLEAR_EMPTY: assert property (@(posedge clk) !clr_n |-> (q == '0)) // R1
    else $error("stages not empty under clear");

  AST_STALL_KEEP: assert property (@(posedge clk) disable iff (!clr_n)
    ($past(clr_n) && $past(act) == ACT_KEEP) |-> $stable(q)) // R2
    else $error("stages moved while stalled");

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!clr_n)
    ($past(clr_n) && $past(act) == ACT_LOAD) |-> (q == $past(pin))) // R3
    else $error("parallel load mismatch");

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
    ($past(clr_n) && $past(act) == ACT_SHIFT) |-> (q == {$past(q[LAST-1:0]), $past(sin)})) // R4
    else $error("shift mismatch");
endmodule

// File: rtl/pl_shifter.sv
`timescale 1ns/1ps
module pl_shifter
  import pl_shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             stall_n,
  input  logic             load_n,
  input  logic             sin,
  input  logic [WIDTH-1:0] pin,
  output logic             sout,
  output logic [WIDTH-1:0] stages
);
  act_e             act;
  logic [WIDTH-1:0] q;

  pl_shifter_ctrl u_ctrl (
    .stall_n (stall_n),
    .load_n  (load_n),
    .act     (act)
  );

  pl_shifter_chain #(.WIDTH(WIDTH)) u_chain (
    .clk   (clk),
    .clr_n (clr_n),
    .act   (act),
    .sin   (sin),
    .pin   (pin),
    .q     (q)
  );

  assign sout   = q[WIDTH-1];
  assign stages = q;

  AST_SOUT_LOW_IN_CLEAR: assert property (@(posedge clk) !clr_n |-> !sout) // R1
    else $error("sout high under clear");

  AST_SOUT_AFTER_LOAD: assert property (@(posedge clk) disable iff (!clr_n)
    ($past(clr_n) && !$past(stall_n) && !$past(load_n)) |-> (sout == $past(pin[WIDTH-1]))) // R5
    else $error("sout not top bit after load");
endmodule

// File: tb/tb_pl_shifter.sv
`timescale 1ns/1ps
module tb_pl_shifter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n, stall_n, load_n, sin;
  logic [W-1:0] pin;
  logic         sout;
  logic [W-1:0] stages;
  logic [W-1:0] model;
  int           total = 0;
  int           bad = 0;

  always #2.5 clk = ~clk;

  pl_shifter #(.WIDTH(W)) dut (
    .clk(clk), .clr_n(clr_n), .stall_n(stall_n), .load_n(load_n),
    .sin(sin), .pin(pin), .sout(sout), .stages(stages)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    clr_n = 1'b0; stall_n = 1'b1; load_n = 1'b1; sin = 1'b0; pin = '0;
    model = '0;
    #1;
    check("R1 stages in clear", stages, '0);
    check("R1 sout in clear", {{(W-1){1'b0}}, sout}, '0);
    tick(); tick();
    clr_n = 1'b1;
    tick();
    check("R2 idle stall after clear", stages, '0);
  endtask

  task automatic load_then_shift();
    logic [W-1:0] pat;
    pat = 8'b1100_1010;
    stall_n = 1'b0; load_n = 1'b0; pin = 8'hA5;
    tick();
    model = 8'hA5;
    check("R3 parallel load", stages, model);
    check("R5 top bit first", {{(W-1){1'b0}}, sout}, {{(W-1){1'b0}}, 1'b1});
    load_n = 1'b1;
    for (int k = 0; k < W; k++) begin
      sin = pat[k];
      tick();
      model = {model[W-2:0], pat[k]};
      check("R4 shift step", stages, model);
      check("R5 sout follows last", {{(W-1){1'b0}}, sout}, {{(W-1){1'b0}}, model[W-1]});
    end
    // after W shifts the first serial bit sits in the last stage
    check("R5 serial bits after loaded bits", stages, {pat[0], pat[1], pat[2], pat[3], pat[4], pat[5], pat[6], pat[7]});
    check("R8 width default 8", 32'(W), 32'd8);
  endtask

  task automatic stall_mid_shift();
    stall_n = 1'b0; load_n = 1'b0; pin = 8'h3C;
    tick(); model = 8'h3C;
    load_n = 1'b1; sin = 1'b1;
    tick(); model = {model[W-2:0], 1'b1};
    check("R4 shift before stall", stages, model);
    stall_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      sin = k[0]; load_n = k[1]; pin = 8'hFF ^ 8'(k);
      tick();
      check("R2 hold while stalled", stages, model);
    end
    load_n = 1'b0; pin = 8'h00;
    tick();
    check("R7 stall beats load", stages, model);
    stall_n = 1'b0; load_n = 1'b1; sin = 1'b0;
    tick(); model = {model[W-2:0], 1'b0};
    check("R4 shift resumes", stages, model);
  endtask

  task automatic no_edge_hold();
    stall_n = 1'b0; load_n = 1'b0; pin = 8'h81;
    #0.5; sin = 1'b1; load_n = 1'b1;
    #0.5; pin = 8'h18;
    #0.5;
    check("R6 no edge no change", stages, model);
    tick();
    model = {model[W-2:0], 1'b1};
    check("R4 shift after quiet interval", stages, model);
  endtask

  task automatic mid_reset();
    stall_n = 1'b0; load_n = 1'b0; pin = 8'hFF;
    tick(); model = 8'hFF;
    check("R3 load all ones", stages, model);
    #0.5;
    clr_n = 1'b0;
    #0.5;
    check("R7 clear acts before next edge", {{(W-1){1'b0}}, sout}, '0);
    check("R1 async clear stages", stages, '0);
    tick();
    check("R7 clear beats load", stages, '0);
    #0.5; clr_n = 1'b1; pin = 8'h96;
    tick();
    check("R3 load after release", stages, 8'h96);
    check("R5 sout after load", {{(W-1){1'b0}}, sout}, {{(W-1){1'b0}}, 1'b1});
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    load_then_shift();
    stall_mid_shift();
    no_edge_hold();
    mid_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule